// File: doc/BRIEF.md
# Byte-Parity Memory Data Path

This block sits between a request stream and a synchronous memory port whose words hold eight data bytes, each with its own parity bit. A write request goes straight to the memory port in the cycle it is accepted. The block computes an odd parity bit for every byte and passes the byte enables on as the memory write mask. A partial write therefore updates only the enabled bytes and their parity bits, and the memory is never read first.

A read request is issued to the memory in the cycle it is accepted, and the word comes back one cycle later. The block recomputes parity on every returned byte and compares it with the stored bit. Any mismatch is an uncorrectable error. The data is still delivered as stored, with an error flag in the same beat. The flagged beat also carries a report to an error-logging unit: the word address and a per-byte mismatch vector. The report is given in the cycle that beat is handed over.

The request input and the read-response output are valid/ready streams. A request transfers on a cycle where `req_valid` and `req_ready` are both high. A response transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. A response that is not taken stays put. While a read is in flight, or while a response is held by back-pressure, `req_ready` is low. This holds off writes as well as reads, so no returned word is ever lost. Memory-side pins and the error report are plain signals with no handshake.

Top module: `bpar_mem_path`

## Requirements
- R1: For every memory write, `mem_wpar[i]` is the odd parity of `mem_wdata[8i+7:8i]`: that byte together with its parity bit holds an odd number of ones.
- R2: In the cycle a write is accepted, `mem_en` and `mem_we` are high and `mem_wmask` equals `req_be`. Bit i of the mask covers data byte i and parity bit i. Bytes whose mask bit is 0 keep their stored data and parity, and a write with an all-zero mask changes nothing.
- R3: In the cycle a read is accepted, `mem_en` is high, `mem_we` is low and `mem_addr` equals `req_addr`. The memory returns `mem_rdata`/`mem_rpar` one cycle later.
- R4: A read response is presented on `rsp_valid` two cycles after the cycle its request was accepted. Responses come back in request order.
- R5: When every returned byte has correct odd parity, `rsp_data` equals the stored word unchanged and `rsp_derr` is 0.
- R6: When any returned byte fails odd parity, `rsp_derr` is 1 in the same beat as that word. The word is delivered as stored, without correction.
- R7: `err_valid` is high exactly in cycles where `rsp_valid`, `rsp_ready` and `rsp_derr` are all high. In those cycles `err_addr` is the word address and bit i of `err_mism` is 1 exactly when byte i failed parity.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_derr` hold their values. `req_ready` is low while a read is in flight or a response is stalled.
- R9: After reset, `rsp_valid` and `err_valid` are 0 and `req_ready` is 1.
- R10: `mem_en` is high only in cycles where a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | NB | Byte enables for writes |
| req_wdata | input | 8*NB | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8*NB | Read data as stored |
| rsp_derr | output | 1 | Parity error in this beat |
| err_valid | output | 1 | Error report strobe |
| err_addr | output | ADDR_W | Address of the failing word |
| err_mism | output | NB | Per-byte parity mismatch vector |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wmask | output | NB | Memory byte write mask |
| mem_wdata | output | 8*NB | Memory write data |
| mem_wpar | output | NB | Memory write parity bits |
| mem_rdata | input | 8*NB | Memory read data, one cycle after a read |
| mem_rpar | input | NB | Memory read parity bits |

## Verification
The memory-side write signals (`mem_en`, `mem_we`, `mem_wmask`, `mem_wpar`) are due in the same cycle as the request handshake. The driver samples them at the falling edge of that accepting cycle. A read response is due two cycles after its accepting cycle. The driver stamps each expected item with the accept cycle. While `rsp_ready` is held high, the monitor requires a distance of exactly two cycles; under back-pressure it requires at least two. The error report is due in the very cycle the flagged beat transfers, so the monitor checks `err_valid`, `err_addr` and `err_mism` at that same falling edge. It also requires `err_valid` low on every other edge.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

  localparam int BYTE_W = 8;

  // Parity bit that makes byte plus bit carry an odd count of ones.
  function automatic logic odd_par(input logic [BYTE_W-1:0] b);
    return ~(^b);
  endfunction

  // 1 when byte and stored bit together still have odd weight.
  function automatic logic byte_ok(input logic [BYTE_W-1:0] b, input logic p);
    return ^{b, p};
  endfunction

endpackage

// File: rtl/bpar_gen.sv
module bpar_gen #(
  parameter int NB = 8,
  localparam int DW = NB * bpar_pkg::BYTE_W
) (
  input  logic [DW-1:0] data,
  output logic [NB-1:0] par
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign par[g] = bpar_pkg::odd_par(data[g*bpar_pkg::BYTE_W +: bpar_pkg::BYTE_W]);
  end
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk #(
  parameter int NB = 8,
  localparam int DW = NB * bpar_pkg::BYTE_W
) (
  input  logic [DW-1:0] data,
  input  logic [NB-1:0] par,
  output logic [NB-1:0] mism
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign mism[g] = ~bpar_pkg::byte_ok(data[g*bpar_pkg::BYTE_W +: bpar_pkg::BYTE_W], par[g]);
  end
endmodule

// File: rtl/bpar_rd_pipe.sv
module bpar_rd_pipe #(
  parameter int AW = 16,
  parameter int NB = 8,
  localparam int DW = NB * bpar_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] rd_data,
  input  logic [NB-1:0] rd_mism,
  input  logic          take,
  output logic          can_accept,
  output logic          out_vld,
  output logic [DW-1:0] out_data,
  output logic [NB-1:0] out_mism,
  output logic [AW-1:0] out_addr
);
  logic          s1_vld;
  logic [AW-1:0] s1_addr;

  // A new request is taken only when the output slot will be free by the
  // time the memory word arrives.
  assign can_accept = !s1_vld && (!out_vld || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_vld <= issue;
      if (issue) s1_addr <= issue_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_mism <= '0;
      out_addr <= '0;
    end else if (s1_vld) begin
      out_vld  <= 1'b1;
      out_data <= rd_data;
      out_mism <= rd_mism;
      out_addr <= s1_addr;
    end else if (take) begin
      out_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/bpar_mem_path.sv
module bpar_mem_path #(
  parameter int ADDR_W = 16,
  parameter int NB = 8,
  localparam int DW = NB * bpar_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NB-1:0]     req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_derr,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [NB-1:0]     err_mism,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NB-1:0]     mem_wmask,
  output logic [DW-1:0]     mem_wdata,
  output logic [NB-1:0]     mem_wpar,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [NB-1:0]     mem_rpar
);
  logic          acc;
  logic          rd_issue;
  logic [NB-1:0] rd_mism;
  logic [NB-1:0] out_mism;

  assign acc      = req_valid && req_ready;
  assign rd_issue = acc && !req_write;

  assign mem_en    = acc;
  assign mem_we    = req_write;
  assign mem_addr  = req_addr;
  assign mem_wmask = req_write ? req_be : '0;
  assign mem_wdata = req_wdata;

  bpar_gen #(.NB(NB)) u_gen (
    .data (req_wdata),
    .par  (mem_wpar)
  );

  bpar_chk #(.NB(NB)) u_chk_rd (
    .data (mem_rdata),
    .par  (mem_rpar),
    .mism (rd_mism)
  );

  bpar_rd_pipe #(.AW(ADDR_W), .NB(NB)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (rd_issue),
    .issue_addr (req_addr),
    .rd_data    (mem_rdata),
    .rd_mism    (rd_mism),
    .take       (rsp_ready),
    .can_accept (req_ready),
    .out_vld    (rsp_valid),
    .out_data   (rsp_data),
    .out_mism   (out_mism),
    .out_addr   (err_addr)
  );

  assign rsp_derr  = |out_mism;
  assign err_mism  = out_mism;
  assign err_valid = rsp_valid && rsp_ready && rsp_derr;
endmodule

// File: rtl/bpar_mem_path_chk.sv
module bpar_mem_path_chk #(
  parameter int ADDR_W = 16,
  parameter int NB = 8,
  localparam int DW = NB * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [NB-1:0]     req_be,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DW-1:0]     rsp_data,
  input logic              rsp_derr,
  input logic              err_valid,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NB-1:0]     mem_wmask,
  input logic [DW-1:0]     mem_wdata,
  input logic [NB-1:0]     mem_wpar
);
  function automatic logic all_odd(input logic [DW-1:0] d, input logic [NB-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NB; i++) ok = ok & (^{d[i*8 +: 8], p[i]});
    return ok;
  endfunction

  p_wpar_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> all_odd(mem_wdata, mem_wpar));

  p_wmask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |-> (mem_en && mem_we && mem_wmask == req_be));

  p_rd_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |-> (mem_en && !mem_we && mem_addr == req_addr));

  p_rsp_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> ##2 rsp_valid);

  p_err_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid == (rsp_valid && rsp_ready && rsp_derr));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_derr)));

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_no_idle_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (req_valid && req_ready));
endmodule

bind bpar_mem_path bpar_mem_path_chk #(.ADDR_W(ADDR_W), .NB(NB)) u_prop (.*);

// File: tb/bpar_mem_path_tb.sv
module bpar_mem_path_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NB = 8;
  localparam int DW = NB * 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [NB-1:0] req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_derr, err_valid, mem_en, mem_we;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] err_addr, mem_addr;
  logic [NB-1:0] err_mism, mem_wmask, mem_wpar, mem_rpar;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpar_mem_path #(.ADDR_W(AW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_derr(rsp_derr), .err_valid(err_valid), .err_addr(err_addr),
    .err_mism(err_mism), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wmask(mem_wmask), .mem_wdata(mem_wdata),
    .mem_wpar(mem_wpar), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar)
  );

  // Synchronous memory model with a fault-injection port.
  logic [DW-1:0] ram_d [DEPTH];
  logic [NB-1:0] ram_p [DEPTH];
  logic inj_req = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [DW-1:0] inj_dx = '0;
  logic [NB-1:0] inj_px = '0;

  always @(posedge clk) begin
    if (inj_req) begin
      ram_d[inj_addr] <= ram_d[inj_addr] ^ inj_dx;
      ram_p[inj_addr] <= ram_p[inj_addr] ^ inj_px;
    end else if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < NB; b++)
          if (mem_wmask[b]) begin
            ram_d[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            ram_p[mem_addr][b] <= mem_wpar[b];
          end
      end else begin
        mem_rdata <= ram_d[mem_addr];
        mem_rpar  <= ram_p[mem_addr];
      end
    end
  end

  // Bench's own view of memory contents and of which bytes are faulty.
  logic [DW-1:0] sh_d [DEPTH];
  logic [NB-1:0] sh_bad [DEPTH];

  typedef struct {
    logic [DW-1:0] d;
    logic [NB-1:0] m;
    logic [AW-1:0] a;
    int            stamp;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit strict_lat = 1'b1, bp_mode = 1'b0, finished = 1'b0;
  logic [7:0] lfsr = 8'h5b;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk) begin
    #1 rsp_ready = bp_mode ? (lfsr[1] | lfsr[4]) : 1'b1;
  end

  function automatic logic [NB-1:0] exp_par(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += int'(d[i*8 + k]);
      p[i] = (ones % 2 == 0);
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, expv);
    end
  endtask

  task automatic send(input bit wr, input logic [AW-1:0] a,
                      input logic [NB-1:0] be, input logic [DW-1:0] d);
    bit acc = 1'b0;
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    while (!acc) begin
      @(negedge clk);
      if (req_ready) begin
        acc = 1'b1;
        if (wr) begin
          chk(mem_en && mem_we, "R2", "write enables", {mem_en, mem_we}, 2'b11);
          chk(mem_wmask == be, "R2", "write mask", mem_wmask, be);
          chk(mem_wpar == exp_par(d), "R1", "odd parity bits", mem_wpar, exp_par(d));
          for (int b = 0; b < NB; b++)
            if (be[b]) begin
              sh_d[a][b*8 +: 8] = d[b*8 +: 8];
              sh_bad[a][b] = 1'b0;
            end
        end else begin
          chk(mem_en && !mem_we && mem_addr == a, "R3", "read issue",
              {mem_en, mem_we, mem_addr}, {2'b10, a});
          e.d = sh_d[a]; e.m = sh_bad[a]; e.a = a; e.stamp = cyc;
          q.push_back(e);
        end
      end else begin
        @(posedge clk); #1;
      end
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [DW-1:0] dx,
                        input logic [NB-1:0] px);
    @(posedge clk); #1;
    inj_req = 1'b1; inj_addr = a; inj_dx = dx; inj_px = px;
    @(posedge clk); #1;
    inj_req = 1'b0;
    sh_d[a] = sh_d[a] ^ dx;
    for (int b = 0; b < NB; b++)
      sh_bad[a][b] = sh_bad[a][b] ^ (^dx[b*8 +: 8]) ^ px[b];
  endtask

  // Monitor / scoreboard
  bit prev_stall = 1'b0;
  logic [DW-1:0] prev_data;
  logic prev_derr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(rsp_valid && rsp_data == prev_data && rsp_derr == prev_derr, "R8",
            "held response", rsp_data, prev_data);
      prev_stall = rsp_valid && !rsp_ready;
      prev_data = rsp_data;
      prev_derr = rsp_derr;
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4", "unexpected response", rsp_data, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (strict_lat)
            chk(cyc - e.stamp == 2, "R4", "latency", cyc - e.stamp, 2);
          else
            chk(cyc - e.stamp >= 2, "R4", "latency", cyc - e.stamp, 2);
          chk(rsp_data == e.d, e.m == 0 ? "R5" : "R6", "read data", rsp_data, e.d);
          chk(rsp_derr == (e.m != 0), "R6", "data error flag", rsp_derr, e.m != 0);
          chk(err_valid == (e.m != 0), "R7", "report strobe", err_valid, e.m != 0);
          if (e.m != 0) begin
            chk(err_addr == e.a, "R7", "report address", err_addr, e.a);
            chk(err_mism == e.m, "R7", "mismatch vector", err_mism, e.m);
          end
        end
      end else begin
        chk(!err_valid, "R7", "no report without transfer", err_valid, 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram_d[i] = '0; ram_p[i] = '1; sh_d[i] = '0; sh_bad[i] = '0;
    end
    mem_rdata = '0; mem_rpar = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !err_valid, "R9", "reset outputs", {rsp_valid, err_valid}, 0);
    chk(req_ready, "R9", "ready after reset", req_ready, 1);
    chk(!mem_en, "R10", "idle memory", mem_en, 0);

    // Full writes and clean reads
    for (int i = 0; i < DEPTH; i++)
      send(1'b1, AW'(i), '1, {8{8'(i * 37 + 1)}} ^ {32'h0f1e2d3c, 32'(i) * 32'h01010101});
    send(1'b1, 4'd14, '1, '0);
    send(1'b1, 4'd15, '1, '1);
    for (int i = 0; i < DEPTH; i++) send(1'b0, AW'(i), '0, '0);

    // Partial and empty-mask writes
    send(1'b1, 4'd3, 8'h0f, 64'hdead_beef_cafe_f00d);
    send(1'b1, 4'd5, 8'ha5, 64'h1122_3344_5566_7788);
    send(1'b1, 4'd6, 8'h00, 64'hffff_ffff_ffff_ffff);
    send(1'b0, 4'd3, '0, '0);
    send(1'b0, 4'd5, '0, '0);
    send(1'b0, 4'd6, '0, '0);
    @(negedge clk);
    chk(!mem_en, "R10", "idle memory", mem_en, 0);

    // Fault injection: data bit, parity bit, two bytes, double flip in one byte
    inject(4'd2, 64'h1, '0);
    inject(4'd9, '0, 8'h80);
    inject(4'd10, 64'h0000_0100_0000_0010, '0);
    inject(4'd11, 64'h0000_0000_0000_0300, '0);
    send(1'b0, 4'd2, '0, '0);
    send(1'b0, 4'd9, '0, '0);
    send(1'b0, 4'd10, '0, '0);
    send(1'b0, 4'd11, '0, '0);
    // Rewriting the faulty byte clears the error
    send(1'b1, 4'd2, 8'h01, 64'h0000_0000_0000_00a7);
    send(1'b0, 4'd2, '0, '0);

    // Back-pressure on the response stream, with writes mixed in
    strict_lat = 1'b0;
    bp_mode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (i % 5 == 4) send(1'b1, AW'(i), 8'(8'h33 << (i % 3)), {4{16'(i * 911)}});
      else send(1'b0, AW'(i * 7), '0, '0);
    end
    bp_mode = 1'b0;
    for (int i = 0; i < 50 && q.size() != 0; i++) @(posedge clk);
    chk(q.size() == 0, "R8", "all responses delivered", q.size(), 0);

    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule